// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the sequence of column addresses for one burst access to a synchronous DRAM bank. A pulse on `load_i` captures a starting column, a burst-length code and an ordering choice. From the next cycle on, the block presents one column per accepted beat on a valid/ready output stream. The burst ends on its own after the programmed number of beats. It also ends when `stop_i` is raised, or it is replaced when a new start column is loaded.

Fixed-length bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. Only the low log2(length) bits of the column change; the upper bits keep their values. These low bits follow either a sequential order (start plus beat index) or an interleaved order (start XOR beat index). A full-page burst walks all 256 columns in sequential order, wraps from the top column to column 0, and runs until it is stopped or reloaded.

The output stream obeys valid/ready rules. A beat is consumed in a cycle where both `col_valid_o` and `col_ready_i` are high. While valid is high and ready is low, the column, valid and last-beat flag are held. The control inputs `load_i` and `stop_i` act whatever the state of ready.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid_o` and `col_last_o` are 0.
- R2: In the cycle after `load_i` is high, `col_valid_o` is 1 and `col_o` equals the loaded `start_col_i`, in any ordering and at any length.
- R3: With `order_i`=0 (sequential), beat k of a burst of length BL in {2,4,8} has its low log2(BL) bits equal to (start+k) mod BL. The upper bits equal those of the start column.
- R4: With `order_i`=1 (interleaved), beat k of a burst of length BL in {2,4,8} has its low log2(BL) bits equal to the start's low bits XOR k. The upper bits equal those of the start column.
- R5: The `len_sel_i` encoding is 0=1 beat, 1=2 beats, 2=4 beats and 3=8 beats. The codes 4 to 7 all select a full page of 2^COL_W (256) columns.
- R6: `col_last_o` is high only on the final beat of a fixed-length burst. After that beat is accepted, `col_valid_o` is 0 in the next cycle unless a load occurs.
- R7: A full-page burst is always sequential and never raises `col_last_o`. It steps to the next column on each accepted beat, wraps from 255 to 0, and stays valid until it is stopped or reloaded.
- R8: When `stop_i` is high and `load_i` is low, `col_valid_o` is 0 in the next cycle. When both are high, the load wins.
- R9: A load during an active burst abandons that burst. The next cycle shows the new start column as beat 0 of the new burst.
- R10: While `col_valid_o` is 1 and `col_ready_i` is 0, with no load or stop, `col_o`, `col_valid_o` and `col_last_o` hold their values in the next cycle.
- R11: Length and order are captured at load. Changes to `len_sel_i` or `order_i` during a burst do not alter the column sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst from `start_col_i` |
| start_col_i | input | COL_W | Starting column of the burst |
| len_sel_i | input | 3 | Burst-length code (see R5) |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | COL_W | Current column address |
| col_valid_o | output | 1 | Column beat is valid |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Several rules are checked by assertions on every cycle: a load is followed by its start column, a stop clears valid, an accepted last beat ends the burst, a stall holds the beat, and a full page never flags last. The exact ordering of columns inside an aligned block, under both orderings and every length code, can only be shown by the bench scenarios. The same holds for the page wrap from 255 to 0, for the capture of length and order at load, and for restarts in the middle of a burst. The bench compares these against a reference model under random back-pressure.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int unsigned LEN_SEL_W = 3;

  typedef enum logic [LEN_SEL_W-1:0] {
    LEN_ONE   = 3'd0,
    LEN_TWO   = 3'd1,
    LEN_FOUR  = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE  = 3'd4
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  output logic                 page_o,
  output logic [COL_W-1:0]     mask_o
);

  localparam int unsigned FIXED_CODES = 4;

  always_comb begin
    page_o = (len_sel_i >= LEN_SEL_W'(FIXED_CODES));
    for (int i = 0; i < COL_W; i++) begin
      if (page_o) mask_o[i] = 1'b1;
      else        mask_o[i] = (i < int'(len_sel_i));
    end
  end

endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;
  logic             use_ilv;

  always_comb begin
    use_ilv = (order_i == ORD_ILV) && !page_i;
    seq_low = (start_i + idx_i) & mask_i;
    ilv_low = (start_i ^ idx_i) & mask_i;
    col_o   = (start_i & ~mask_i) | (use_ilv ? ilv_low : seq_low);
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             ready_i,
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  order_e           order_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] start_q_o,
  output logic [COL_W-1:0] mask_q_o,
  output logic             page_q_o,
  output order_e           order_q_o
);

  logic at_end;
  logic accept;

  assign at_end = !page_q_o && (idx_o == mask_q_o);
  assign last_o = active_o && at_end;
  assign accept = active_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      idx_o     <= '0;
      start_q_o <= '0;
      mask_q_o  <= '0;
      page_q_o  <= 1'b0;
      order_q_o <= ORD_SEQ;
    end else if (load_i) begin
      active_o  <= 1'b1;
      idx_o     <= '0;
      start_q_o <= start_i;
      mask_q_o  <= mask_i;
      page_q_o  <= page_i;
      order_q_o <= order_i;
    end else if (stop_i) begin
      active_o <= 1'b0;
    end else if (accept) begin
      if (at_end) active_o <= 1'b0;
      else        idx_o    <= idx_o + 1'b1;
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> active_o); // R6
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && ready_i && !load_i) |=> !active_o); // R6
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    page_q_o |-> !last_o); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> !active_o); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !ready_i && !load_i && !stop_i) |=> (active_o && $stable(idx_o) && $stable(last_o))); // R10

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  input  logic                 order_i,
  input  logic                 stop_i,
  output logic [COL_W-1:0]     col_o,
  output logic                 col_valid_o,
  input  logic                 col_ready_i,
  output logic                 col_last_o
);

  localparam int unsigned MIN_COL_W = 4;

  logic             dec_page;
  logic [COL_W-1:0] dec_mask;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  order_e           order_q;
  order_e           order_in;

  assign order_in = order_e'(order_i);

  generate
    if (COL_W < MIN_COL_W) begin : g_bad_width
      initial $error("COL_W must be at least %0d", MIN_COL_W);
    end
  endgenerate

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_sel_i (len_sel_i),
    .page_o    (dec_page),
    .mask_o    (dec_mask)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .stop_i    (stop_i),
    .ready_i   (col_ready_i),
    .start_i   (start_col_i),
    .mask_i    (dec_mask),
    .page_i    (dec_page),
    .order_i   (order_in),
    .active_o  (col_valid_o),
    .last_o    (col_last_o),
    .idx_o     (idx),
    .start_q_o (start_q),
    .mask_q_o  (mask_q),
    .page_q_o  (page_q),
    .order_q_o (order_q)
  );

  burst_col_order #(.COL_W(COL_W)) u_order (
    .start_i (start_q),
    .idx_i   (idx),
    .mask_i  (mask_q),
    .page_i  (page_q),
    .order_i (order_q),
    .col_o   (col_o)
  );

  AST_LOAD_SHOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (col_valid_o && col_o == $past(start_col_i))); // R2
  AST_STALL_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_ready_i && !load_i && !stop_i) |=> $stable(col_o)); // R10

endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

  localparam int unsigned COL_W = 8;
  localparam int unsigned PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_sel_i = '0;
  logic             order_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             col_ready_i = 1'b1;
  logic [COL_W-1:0] col_o;
  logic             col_valid_o;
  logic             col_last_o;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R2";

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
    .len_sel_i(len_sel_i), .order_i(order_i), .stop_i(stop_i),
    .col_o(col_o), .col_valid_o(col_valid_o), .col_ready_i(col_ready_i),
    .col_last_o(col_last_o)
  );

  // Reference model state
  logic     m_act;
  int       m_start, m_idx, m_bl;
  logic     m_page, m_ilv;

  function automatic int exp_col(int st, int k, int bl, logic page, logic ilv);
    int m;
    if (page) return (st + k) % PAGE;
    m = bl - 1;
    if (ilv) return (st & ~m) | ((st ^ k) & m);
    return (st & ~m) | ((st + k) & m);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0; m_start <= 0; m_idx <= 0; m_bl <= 1; m_page <= 1'b0; m_ilv <= 1'b0;
    end else if (load_i) begin
      m_act <= 1'b1; m_start <= int'(start_col_i); m_idx <= 0;
      m_page <= (len_sel_i >= 3'd4);
      m_bl <= (len_sel_i >= 3'd4) ? PAGE : (1 << len_sel_i);
      m_ilv <= order_i;
    end else if (stop_i) begin
      m_act <= 1'b0;
    end else if (m_act && col_ready_i) begin
      if (!m_page && m_idx == m_bl - 1) m_act <= 1'b0;
      else m_idx <= (m_idx + 1) % PAGE;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string ct;
    chk(cur_tag, int'(col_valid_o), int'(m_act));
    chk(m_page ? "R7" : "R6", int'(col_last_o),
        int'(m_act && !m_page && m_idx == m_bl - 1));
    if (m_act) begin
      ct = m_page ? "R7" : (m_ilv ? "R4" : "R3");
      chk(ct, int'(col_o), exp_col(m_start, m_idx, m_bl, m_page, m_ilv));
    end
  endtask

  task automatic step(logic ld, int st, int len, logic ilv, logic stp, logic rdy);
    load_i = ld; start_col_i = COL_W'(st); len_sel_i = 3'(len);
    order_i = ilv; stop_i = stp; col_ready_i = rdy;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, logic rdy);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, rdy);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("R1", int'(col_valid_o), 0);
    chk("R1", int'(col_last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(col_valid_o), 0);

    cur_tag = "R2";
    step(1'b1, 8'h35, 3, 1'b0, 1'b0, 1'b1);
    chk("R2", int'(col_o), 8'h35);
    cur_tag = "R3";
    idle(8, 1'b1);
    cur_tag = "R4";
    step(1'b1, 8'h35, 3, 1'b1, 1'b0, 1'b1);
    chk("R4", int'(col_o), 8'h35);
    step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
    chk("R4", int'(col_o), 8'h34);
    idle(7, 1'b1);

    cur_tag = "R5";
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 8'h6B, c, c[0], 1'b0, 1'b1);
      idle(10, 1'b1);
    end

    cur_tag = "R7";
    step(1'b1, 8'hFD, 4, 1'b1, 1'b0, 1'b1);
    idle(3, 1'b1);
    chk("R7", int'(col_o), 8'h00);
    idle(300, 1'b1);
    cur_tag = "R8";
    step(1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
    chk("R8", int'(col_valid_o), 0);
    step(1'b1, 8'h10, 3, 1'b0, 1'b1, 1'b1);
    chk("R8", int'(col_valid_o), 1);

    cur_tag = "R9";
    idle(2, 1'b1);
    step(1'b1, 8'hA7, 2, 1'b0, 1'b0, 1'b1);
    chk("R9", int'(col_o), 8'hA7);
    idle(5, 1'b1);

    cur_tag = "R10";
    step(1'b1, 8'h42, 3, 1'b0, 1'b0, 1'b0);
    idle(4, 1'b0);
    chk("R10", int'(col_o), 8'h42);
    idle(10, 1'b1);

    cur_tag = "R11";
    step(1'b1, 8'h21, 2, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 8'hFF, 7 - i, ~i[0], 1'b0, 1'b1);

    cur_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      step(r < 12, $urandom_range(255), $urandom_range(7), 1'($urandom_range(1)),
           (r >= 12 && r < 15), ($urandom_range(3) != 0));
    end
    idle(300, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule